// File: doc/BRIEF.md
# Serial channel mode and command register file

This block is the host-side register interface of one channel in a multi-channel asynchronous serial controller. It decodes byte-wide reads and writes on a simple strobe bus and keeps the channel's configuration: three mode registers, a clock-select register, the receiver and transmitter enables and a break request. The serializer, the baud generator and the FIFOs sit outside. Live status comes in on a small input bus, error events come in as single-cycle pulses, and received and transmitted bytes pass through plain data ports.

The three mode registers share a single bus address. A pointer chooses which one an access reaches. A command sets the pointer, and every mode access moves it along. The enables for each direction have separate on and off command bits, so one write can turn one direction on and the other off. The settings go to the serializer as decoded fields: word length, parity enable and sense, stop bits, FIFO options and the clock-select codes.

Top module: `uart_chan_regs`

## Requirements
- R1: The channel answers only at addresses CHAN_IDX*8 + k, with k = 0 for mode, 1 for status (read) / clock select (write), 2 for command and 3 for data. Accesses to any other address change no state, read as 0x00 and do not assert rx_pop. Reads of the command offset return 0x00.
- R2: After reset the mode pointer selects MR1. Command code 0x1 (bits 7:4) sets it to MR1 and code 0xB sets it to MR0. Each read or write at offset 0 uses the selected register and then moves the pointer MR0 to MR1 to MR2.
- R3: Once the pointer reaches MR2 it stays there on further mode accesses until a pointer command arrives.
- R4: MR1 bits 1:0 drive word_len (00 = 5 bits through 11 = 8 bits). Parity field MR1 bits 4:2 gives even parity for 000 (par_en=1, par_odd=0) and odd parity for 001 (par_en=1, par_odd=1). Any value with bit 4 or bit 3 set turns parity off (par_en=0). Bit 2 drives par_odd.
- R5: MR2 bit 3 drives stop_two: 0x7 gives one stop bit and 0xF gives two. MR0 bit 3 drives fifo_ext, MR0 bit 4 drives tx_half and MR0 bits 2:0 drive baud_tbl.
- R6: A write to offset 1 loads rx_clk_sel from bits 3:0 and tx_clk_sel from bits 7:4.
- R7: In a command write, bit 0 turns the receiver on, bit 1 turns it off, bit 2 turns the transmitter on and bit 3 turns it off. When on and off for the same direction arrive together, off wins. The two directions act independently in the same write.
- R8: Command code 0x2 turns the receiver off and pulses rx_rst for one cycle. Code 0x3 does the same for the transmitter with tx_rst. In both cases the reset wins over an on bit in the same write. Code 0x5 pulses brk_chg_clr. Code 0x6 sets brk_on and code 0x7 clears it. Each pulse appears in the cycle after the write.
- R9: A status read returns {brk, framing, parity, overrun, tx_empty, tx_ready, rx_full, rx_ready} from bit 7 down to bit 0. The low nibble is stat_live[3:0]. The high nibble holds sticky flags that are set by err_evt[3:0] (bit 0 overrun through bit 3 break).
- R10: Command code 0x4 clears all four sticky error flags. An error event in the same cycle as that command is kept.
- R11: A write to offset 3 puts the byte on tx_byte and pulses tx_push in the next cycle. A read of offset 3 returns rx_byte and asserts rx_pop in the same cycle.
- R12: Reset clears all mode registers, both clock selects, both enables, brk_on and every pulse output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| stat_live | input | 4 | {tx_empty, tx_ready, rx_full, rx_ready} from the serializer |
| err_evt | input | 4 | Error event pulses {break, framing, parity, overrun} |
| rx_byte | input | 8 | Head of the receive queue |
| rx_pop | output | 1 | Receive byte consumed this cycle |
| tx_byte | output | 8 | Last byte written for transmission |
| tx_push | output | 1 | One-cycle pulse: tx_byte is new |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| brk_on | output | 1 | Hold the line in break |
| rx_rst | output | 1 | Receiver reset pulse |
| tx_rst | output | 1 | Transmitter reset pulse |
| brk_chg_clr | output | 1 | Clear pulse for the break-change latch |
| word_len | output | 2 | Data bits minus five |
| par_en | output | 1 | Parity generated and checked |
| par_odd | output | 1 | Odd parity when set |
| stop_two | output | 1 | Two stop bits when set |
| fifo_ext | output | 1 | Extended FIFO enable |
| tx_half | output | 1 | Transmit interrupt at half full |
| baud_tbl | output | 3 | Baud table select |
| rx_clk_sel | output | 4 | Receive clock-select code |
| tx_clk_sel | output | 4 | Transmit clock-select code |

## Verification
Two functions can land in the same cycle. An error event from the serializer can arrive while the host writes the status-clear command. The bench first latches one flag, then pulses a different event in the exact cycle of the clear write. It judges the result by a later status read: the old flag must be gone and the new one must be set. A second collision is inside one command byte, where on and off bits or a reset code combine with an on bit. For that case the bench checks the enables after each such write.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;

  localparam int REG_DW  = 8;
  localparam int OFS_W   = 3;   // a channel spans 8 addresses
  localparam int NUM_OFS = 4;   // offsets owned by the channel
  localparam int ERR_N   = 4;
  localparam int LIVE_N  = 4;
  localparam int NUM_MR  = 3;

  localparam int OFS_MODE = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CMD  = 2;
  localparam int OFS_DATA = 3;

  typedef enum logic [1:0] {
    PTR_MR0 = 2'd0,
    PTR_MR1 = 2'd1,
    PTR_MR2 = 2'd2
  } mr_ptr_e;

  typedef enum logic [3:0] {
    CMD_NOP        = 4'h0,
    CMD_PTR_MR1    = 4'h1,
    CMD_RX_RST     = 4'h2,
    CMD_TX_RST     = 4'h3,
    CMD_ERR_CLR    = 4'h4,
    CMD_BRKCHG_CLR = 4'h5,
    CMD_BRK_ON     = 4'h6,
    CMD_BRK_OFF    = 4'h7,
    CMD_PTR_MR0    = 4'hB
  } cmd_code_e;

  // Pointer advance: MR0 -> MR1 -> MR2, then hold.
  function automatic mr_ptr_e ptr_step(input mr_ptr_e cur);
    return (cur == PTR_MR0) ? PTR_MR1 : PTR_MR2;
  endfunction

endpackage

// File: rtl/uart_chan_decode.sv
module uart_chan_decode
  import uart_chan_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CHAN_IDX = 1
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  output logic [NUM_OFS-1:0] wr_sel,
  output logic [NUM_OFS-1:0] rd_sel
);

  localparam int              HI_W     = ADDR_W - OFS_W;
  localparam logic [HI_W-1:0] CHAN_TAG = HI_W'(CHAN_IDX);

  logic chan_hit;
  assign chan_hit = (addr[ADDR_W-1:OFS_W] == CHAN_TAG);

  for (genvar k = 0; k < NUM_OFS; k++) begin : g_sel
    logic ofs_hit;
    assign ofs_hit   = chan_hit && (addr[OFS_W-1:0] == OFS_W'(k));
    assign wr_sel[k] = wr && ofs_hit;
    assign rd_sel[k] = rd && ofs_hit;
  end

endmodule

// File: rtl/uart_chan_mode_bank.sv
module uart_chan_mode_bank
  import uart_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              acc_rd,
  input  logic [REG_DW-1:0] wdata,
  input  logic              sel_mr1,
  input  logic              sel_mr0,
  output mr_ptr_e           ptr,
  output logic [REG_DW-1:0] rd_val,
  output logic [1:0]        word_len,
  output logic              par_en,
  output logic              par_odd,
  output logic              stop_two,
  output logic              fifo_ext,
  output logic              tx_half,
  output logic [2:0]        baud_tbl
);

  logic [REG_DW-1:0] mr_q [NUM_MR];
  mr_ptr_e           ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (sel_mr1)              ptr_d = PTR_MR1;
    else if (sel_mr0)         ptr_d = PTR_MR0;
    else if (acc_wr || acc_rd) ptr_d = ptr_step(ptr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= PTR_MR1;
    else        ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < NUM_MR; i++) begin : g_mr
    logic load_en;
    assign load_en = acc_wr && (ptr_q == mr_ptr_e'(2'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mr_q[i] <= '0;
      else if (load_en) mr_q[i] <= wdata;
    end
  end

  always_comb begin
    unique case (ptr_q)
      PTR_MR0: rd_val = mr_q[0];
      PTR_MR1: rd_val = mr_q[1];
      PTR_MR2: rd_val = mr_q[2];
      default: rd_val = '0;
    endcase
  end

  assign ptr      = ptr_q;
  assign word_len = mr_q[1][1:0];
  assign par_en   = (mr_q[1][4:3] == 2'b00);
  assign par_odd  = mr_q[1][2];
  assign stop_two = mr_q[2][3];
  assign fifo_ext = mr_q[0][3];
  assign tx_half  = mr_q[0][4];
  assign baud_tbl = mr_q[0][2:0];

endmodule

// File: rtl/uart_chan_cmd_ctrl.sv
module uart_chan_cmd_ctrl
  import uart_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [REG_DW-1:0] cmd_byte,
  input  logic [ERR_N-1:0]  err_evt,
  output logic              rx_en,
  output logic              tx_en,
  output logic              brk_on,
  output logic              rx_rst_p,
  output logic              tx_rst_p,
  output logic              brk_clr_p,
  output logic              sel_mr1,
  output logic              sel_mr0,
  output logic [ERR_N-1:0]  err_flags
);

  cmd_code_e code;
  logic is_rx_rst, is_tx_rst, is_err_clr, is_brk_clr, is_brk_on, is_brk_off;
  logic rx_en_q, rx_en_d, tx_en_q, tx_en_d, brk_q, brk_d;
  logic rx_rst_q, tx_rst_q, brk_clr_q;
  logic [ERR_N-1:0] err_q, err_d;

  assign code       = cmd_code_e'(cmd_byte[7:4]);
  assign is_rx_rst  = cmd_wr && (code == CMD_RX_RST);
  assign is_tx_rst  = cmd_wr && (code == CMD_TX_RST);
  assign is_err_clr = cmd_wr && (code == CMD_ERR_CLR);
  assign is_brk_clr = cmd_wr && (code == CMD_BRKCHG_CLR);
  assign is_brk_on  = cmd_wr && (code == CMD_BRK_ON);
  assign is_brk_off = cmd_wr && (code == CMD_BRK_OFF);
  assign sel_mr1    = cmd_wr && (code == CMD_PTR_MR1);
  assign sel_mr0    = cmd_wr && (code == CMD_PTR_MR0);

  // Off and reset win over on, per direction.
  always_comb begin
    rx_en_d = rx_en_q;
    tx_en_d = tx_en_q;
    brk_d   = brk_q;
    if (cmd_wr && cmd_byte[0])            rx_en_d = 1'b1;
    if (cmd_wr && cmd_byte[1] || is_rx_rst) rx_en_d = 1'b0;
    if (cmd_wr && cmd_byte[2])            tx_en_d = 1'b1;
    if (cmd_wr && cmd_byte[3] || is_tx_rst) tx_en_d = 1'b0;
    if (is_brk_on)                        brk_d   = 1'b1;
    if (is_brk_off)                       brk_d   = 1'b0;
  end

  // Sticky error flags: a new event outranks a clear in the same cycle.
  for (genvar i = 0; i < ERR_N; i++) begin : g_err
    assign err_d[i] = err_evt[i] || (err_q[i] && !is_err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      brk_q     <= 1'b0;
      rx_rst_q  <= 1'b0;
      tx_rst_q  <= 1'b0;
      brk_clr_q <= 1'b0;
      err_q     <= '0;
    end else begin
      rx_en_q   <= rx_en_d;
      tx_en_q   <= tx_en_d;
      brk_q     <= brk_d;
      rx_rst_q  <= is_rx_rst;
      tx_rst_q  <= is_tx_rst;
      brk_clr_q <= is_brk_clr;
      err_q     <= err_d;
    end
  end

  assign rx_en     = rx_en_q;
  assign tx_en     = tx_en_q;
  assign brk_on    = brk_q;
  assign rx_rst_p  = rx_rst_q;
  assign tx_rst_p  = tx_rst_q;
  assign brk_clr_p = brk_clr_q;
  assign err_flags = err_q;

endmodule

// File: rtl/uart_chan_regs.sv
module uart_chan_regs
  import uart_chan_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CHAN_IDX = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [3:0]        stat_live,
  input  logic [3:0]        err_evt,
  input  logic [7:0]        rx_byte,
  output logic              rx_pop,
  output logic [7:0]        tx_byte,
  output logic              tx_push,
  output logic              rx_en,
  output logic              tx_en,
  output logic              brk_on,
  output logic              rx_rst,
  output logic              tx_rst,
  output logic              brk_chg_clr,
  output logic [1:0]        word_len,
  output logic              par_en,
  output logic              par_odd,
  output logic              stop_two,
  output logic              fifo_ext,
  output logic              tx_half,
  output logic [2:0]        baud_tbl,
  output logic [3:0]        rx_clk_sel,
  output logic [3:0]        tx_clk_sel
);

  localparam int CS_W = REG_DW / 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [NUM_OFS-1:0] wr_sel, rd_sel;

  uart_chan_decode #(.ADDR_W(ADDR_W), .CHAN_IDX(CHAN_IDX)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  logic              sel_mr1, sel_mr0;
  logic [ERR_N-1:0]  err_flags;
  logic [REG_DW-1:0] mode_rd;
  mr_ptr_e           mode_ptr;

  uart_chan_cmd_ctrl u_cmd (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cmd_wr    (wr_sel[OFS_CMD]),
    .cmd_byte  (bus_wdata),
    .err_evt   (err_evt),
    .rx_en     (rx_en),
    .tx_en     (tx_en),
    .brk_on    (brk_on),
    .rx_rst_p  (rx_rst),
    .tx_rst_p  (tx_rst),
    .brk_clr_p (brk_chg_clr),
    .sel_mr1   (sel_mr1),
    .sel_mr0   (sel_mr0),
    .err_flags (err_flags)
  );

  uart_chan_mode_bank u_mode (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .acc_wr   (wr_sel[OFS_MODE]),
    .acc_rd   (rd_sel[OFS_MODE]),
    .wdata    (bus_wdata),
    .sel_mr1  (sel_mr1),
    .sel_mr0  (sel_mr0),
    .ptr      (mode_ptr),
    .rd_val   (mode_rd),
    .word_len (word_len),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .stop_two (stop_two),
    .fifo_ext (fifo_ext),
    .tx_half  (tx_half),
    .baud_tbl (baud_tbl)
  );

  // Clock select and transmit holding register.
  logic [REG_DW-1:0] csel_q, csel_d, txh_q, txh_d;
  logic              push_q;

  always_comb begin
    csel_d = csel_q;
    txh_d  = txh_q;
    if (wr_sel[OFS_STAT]) csel_d = bus_wdata;
    if (wr_sel[OFS_DATA]) txh_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      csel_q <= '0;
      txh_q  <= '0;
      push_q <= 1'b0;
    end else begin
      csel_q <= csel_d;
      txh_q  <= txh_d;
      push_q <= wr_sel[OFS_DATA];
    end
  end

  assign rx_clk_sel = csel_q[CS_W-1:0];
  assign tx_clk_sel = csel_q[REG_DW-1:CS_W];
  assign tx_byte    = txh_q;
  assign tx_push    = push_q;
  assign rx_pop     = rd_sel[OFS_DATA];

  always_comb begin
    bus_rdata = '0;
    if (rd_sel[OFS_MODE])      bus_rdata = mode_rd;
    else if (rd_sel[OFS_STAT]) bus_rdata = {err_flags, stat_live};
    else if (rd_sel[OFS_DATA]) bus_rdata = rx_byte;
  end

endmodule

// File: rtl/uart_chan_regs_chk.sv
module uart_chan_regs_chk
  import uart_chan_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CHAN_IDX = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic              rx_en,
  input logic              tx_en,
  input logic              brk_on,
  input logic              rx_rst,
  input logic              tx_rst,
  input logic              brk_chg_clr,
  input logic              tx_push,
  input logic [1:0]        mode_ptr,
  input logic [3:0]        rx_clk_sel,
  input logic [3:0]        tx_clk_sel
);

  localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'(CHAN_IDX * 8 + OFS_CMD);
  localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(CHAN_IDX * 8 + OFS_DATA);

  logic       cmd_wr, data_wr;
  logic [3:0] code;
  assign cmd_wr  = bus_wr && (bus_addr == CMD_ADDR);
  assign data_wr = bus_wr && (bus_addr == DATA_ADDR);
  assign code    = bus_wdata[7:4];

  AST_RX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[1]) |=> !rx_en);  // R7
  AST_TX_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[3]) |=> !tx_en);  // R7
  AST_RX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[0] && !bus_wdata[1] && code != 4'h2) |=> rx_en);  // R7
  AST_TX_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[2] && !bus_wdata[3] && code != 4'h3) |=> tx_en);  // R7
  AST_RX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && code == 4'h2) |=> (rx_rst && !rx_en));  // R8
  AST_TX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && code == 4'h3) |=> (tx_rst && !tx_en));  // R8
  AST_BRK_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && code == 4'h6) |=> brk_on);  // R8
  AST_BRK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && code == 4'h7) |=> !brk_on);  // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_rst, tx_rst, brk_chg_clr}));  // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ptr == 2'd2 && !(cmd_wr && (code == 4'h1 || code == 4'hB)))
      |=> (mode_ptr == 2'd2));  // R3
  AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ptr != 2'd3);  // R2
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && !bus_rd) |=> $stable(mode_ptr));  // R2
  AST_CSEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable({rx_clk_sel, tx_clk_sel}));  // R6
  AST_PUSH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> tx_push);  // R11
  AST_NO_STRAY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> !tx_push);  // R11

endmodule

bind uart_chan_regs uart_chan_regs_chk #(.ADDR_W(ADDR_W), .CHAN_IDX(CHAN_IDX)) chk_i (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .rx_en       (rx_en),
  .tx_en       (tx_en),
  .brk_on      (brk_on),
  .rx_rst      (rx_rst),
  .tx_rst      (tx_rst),
  .brk_chg_clr (brk_chg_clr),
  .tx_push     (tx_push),
  .mode_ptr    (mode_ptr),
  .rx_clk_sel  (rx_clk_sel),
  .tx_clk_sel  (tx_clk_sel)
);

// File: tb/uart_chan_regs_tb_top.sv
`timescale 1ns/1ps
module uart_chan_regs_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] stat_live = '0;
  logic [3:0] err_evt = '0;
  logic [7:0] rx_byte = '0;
  logic       rx_pop;
  logic [7:0] tx_byte;
  logic       tx_push, rx_en, tx_en, brk_on, rx_rst, tx_rst, brk_chg_clr;
  logic [1:0] word_len;
  logic       par_en, par_odd, stop_two, fifo_ext, tx_half;
  logic [2:0] baud_tbl;
  logic [3:0] rx_clk_sel, tx_clk_sel;

  int tests = 0;
  int fails = 0;
  logic [7:0] rd_got;
  logic       pop_got;

  always #2.5 clk = ~clk;

  uart_chan_regs #(.ADDR_W(4), .CHAN_IDX(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stat_live(stat_live), .err_evt(err_evt), .rx_byte(rx_byte),
    .rx_pop(rx_pop), .tx_byte(tx_byte), .tx_push(tx_push), .rx_en(rx_en),
    .tx_en(tx_en), .brk_on(brk_on), .rx_rst(rx_rst), .tx_rst(tx_rst),
    .brk_chg_clr(brk_chg_clr), .word_len(word_len), .par_en(par_en),
    .par_odd(par_odd), .stop_two(stop_two), .fifo_ext(fifo_ext),
    .tx_half(tx_half), .baud_tbl(baud_tbl), .rx_clk_sel(rx_clk_sel),
    .tx_clk_sel(tx_clk_sel)
  );

  // cfg word: {rx,tx,brk,pe,po,wl[1:0],st,fe,th,bt[2:0],rcs[3:0],tcs[3:0]}
  function automatic logic [20:0] c(input logic rx, tx, brk, pe, po,
                                    input logic [1:0] wl, input logic st, fe, th,
                                    input logic [2:0] bt, input logic [3:0] rcs, tcs);
    return {rx, tx, brk, pe, po, wl, st, fe, th, bt, rcs, tcs};
  endfunction

  // vector: {is_read, addr[3:0], data_or_expected_read[7:0], cfg_after[20:0]}
  function automatic logic [33:0] v(input logic rd, input logic [3:0] a,
                                    input logic [7:0] d, input logic [20:0] cf);
    return {rd, a, d, cf};
  endfunction

  localparam int NV = 33;
  localparam logic [33:0] VECS [NV] = '{
    v(1'b0, 4'h8, 8'h13, c(0,0,0,1'b0,0,2'd3,0,0,0,3'd0,4'h0,4'h0)), // R2 R4 MR1 first
    v(1'b0, 4'h8, 8'h0F, c(0,0,0,1'b0,0,2'd3,1,0,0,3'd0,4'h0,4'h0)), // R5 MR2 two stop
    v(1'b0, 4'h8, 8'h07, c(0,0,0,1'b0,0,2'd3,0,0,0,3'd0,4'h0,4'h0)), // R3 hold at MR2
    v(1'b1, 4'h8, 8'h07, c(0,0,0,1'b0,0,2'd3,0,0,0,3'd0,4'h0,4'h0)), // R3
    v(1'b0, 4'hA, 8'h10, c(0,0,0,1'b0,0,2'd3,0,0,0,3'd0,4'h0,4'h0)), // R2 ptr MR1
    v(1'b1, 4'h8, 8'h13, c(0,0,0,1'b0,0,2'd3,0,0,0,3'd0,4'h0,4'h0)), // R2
    v(1'b1, 4'h8, 8'h07, c(0,0,0,1'b0,0,2'd3,0,0,0,3'd0,4'h0,4'h0)), // R2
    v(1'b0, 4'hA, 8'hB0, c(0,0,0,1'b0,0,2'd3,0,0,0,3'd0,4'h0,4'h0)), // R2 ptr MR0
    v(1'b0, 4'h8, 8'h19, c(0,0,0,1'b0,0,2'd3,0,1,1,3'd1,4'h0,4'h0)), // R5 MR0
    v(1'b0, 4'h8, 8'h06, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'h0,4'h0)), // R4 odd 7 bits
    v(1'b1, 4'h8, 8'h07, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'h0,4'h0)), // R3
    v(1'b0, 4'h9, 8'hBB, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hB,4'hB)), // R6
    v(1'b0, 4'h9, 8'h5C, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R6
    v(1'b0, 4'hA, 8'h05, c(1,1,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R7
    v(1'b0, 4'hA, 8'h06, c(0,1,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R7
    v(1'b0, 4'hA, 8'h09, c(1,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R7
    v(1'b0, 4'hA, 8'h60, c(1,0,1,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R8 brk on
    v(1'b0, 4'hA, 8'h70, c(1,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R8 brk off
    v(1'b0, 4'hA, 8'h04, c(1,1,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R7
    v(1'b0, 4'hA, 8'h20, c(0,1,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R8 rx reset
    v(1'b0, 4'hA, 8'h30, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R8 tx reset
    v(1'b0, 4'hA, 8'h01, c(1,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R7
    v(1'b0, 4'hA, 8'h03, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R7 off wins
    v(1'b0, 4'hA, 8'h21, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R8 reset wins
    v(1'b0, 4'h0, 8'hFF, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R1 foreign
    v(1'b0, 4'h1, 8'h00, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R1 foreign
    v(1'b0, 4'h2, 8'h05, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R1 foreign
    v(1'b1, 4'hA, 8'h00, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R1 cmd reads 0
    v(1'b0, 4'hA, 8'hB0, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R2
    v(1'b1, 4'h8, 8'h19, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R2 MR0
    v(1'b1, 4'h8, 8'h06, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R2 MR1
    v(1'b1, 4'h8, 8'h07, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5)), // R2 MR2
    v(1'b0, 4'h3, 8'hAA, c(0,0,0,1'b1,1,2'd2,0,1,1,3'd1,4'hC,4'h5))  // R1 foreign
  };

  function automatic logic [20:0] cfg_now();
    return {rx_en, tx_en, brk_on, par_en, par_odd, word_len, stop_two, fifo_ext,
            tx_half, baud_tbl, rx_clk_sel, tx_clk_sel};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive in the low phase, sample read data before the edge, outputs after it.
  task automatic bus_op(input logic rd, input logic wr, input logic [3:0] a,
                        input logic [7:0] d, input logic [3:0] ev);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d; err_evt = ev;
    #0.5;
    rd_got  = bus_rdata;
    pop_got = rx_pop;
    @(posedge clk);
    #0.5;
    bus_rd = 1'b0; bus_wr = 1'b0; err_evt = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #0.5;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R12 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    // Reset state
    check("R12 cfg after reset", 32'(cfg_now()), 32'(c(0,0,0,1'b1,0,2'd0,0,0,0,3'd0,4'h0,4'h0)));
    check("R12 pulses after reset", {28'd0, rx_rst, tx_rst, brk_chg_clr, tx_push}, 32'd0);
    bus_op(1'b1, 1'b0, 4'h9, 8'h00, 4'h0);
    check("R12 status after reset", 32'(rd_got), 32'h00);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [33:0] vec;
      vec = VECS[i];
      bus_op(vec[33], !vec[33], vec[32:29], vec[28:21], 4'h0);
      if (vec[33]) check($sformatf("R2 read vec %0d", i), 32'(rd_got), 32'(vec[28:21]));
      check($sformatf("R7 cfg vec %0d", i), 32'(cfg_now()), 32'(vec[20:0]));
    end

    // R9: live status bits
    stat_live = 4'b1010;
    bus_op(1'b1, 1'b0, 4'h9, 8'h00, 4'h0);
    check("R9 live status", 32'(rd_got), 32'h0A);
    check("R11 no pop on status read", 32'(pop_got), 32'd0);
    // R9: sticky error flags
    bus_op(1'b0, 1'b0, 4'h0, 8'h00, 4'b0101);
    bus_op(1'b1, 1'b0, 4'h9, 8'h00, 4'h0);
    check("R9 sticky set", 32'(rd_got), 32'h5A);
    bus_op(1'b1, 1'b0, 4'h9, 8'h00, 4'h0);
    check("R9 sticky held", 32'(rd_got), 32'h5A);
    // R10: clear
    bus_op(1'b0, 1'b1, 4'hA, 8'h40, 4'h0);
    bus_op(1'b1, 1'b0, 4'h9, 8'h00, 4'h0);
    check("R10 clear", 32'(rd_got), 32'h0A);
    // R10: event coinciding with clear survives
    bus_op(1'b0, 1'b0, 4'h0, 8'h00, 4'b0001);
    bus_op(1'b0, 1'b1, 4'hA, 8'h40, 4'b0010);
    bus_op(1'b1, 1'b0, 4'h9, 8'h00, 4'h0);
    check("R10 same-cycle event kept", 32'(rd_got), 32'h2A);

    // R8: pulses
    bus_op(1'b0, 1'b1, 4'hA, 8'h20, 4'h0);
    check("R8 rx_rst pulse", 32'(rx_rst), 32'd1);
    bus_op(1'b0, 1'b0, 4'h0, 8'h00, 4'h0);
    check("R8 rx_rst one cycle", 32'(rx_rst), 32'd0);
    bus_op(1'b0, 1'b1, 4'hA, 8'h30, 4'h0);
    check("R8 tx_rst pulse", 32'(tx_rst), 32'd1);
    bus_op(1'b0, 1'b1, 4'hA, 8'h50, 4'h0);
    check("R8 brk_chg_clr pulse", {30'd0, brk_chg_clr, tx_rst}, 32'd2);

    // R11: data path
    bus_op(1'b0, 1'b1, 4'hB, 8'h3C, 4'h0);
    check("R11 tx_push", 32'(tx_push), 32'd1);
    check("R11 tx_byte", 32'(tx_byte), 32'h3C);
    bus_op(1'b0, 1'b0, 4'h0, 8'h00, 4'h0);
    check("R11 tx_push one cycle", 32'(tx_push), 32'd0);
    rx_byte = 8'h9D;
    bus_op(1'b1, 1'b0, 4'hB, 8'h00, 4'h0);
    check("R11 rx read data", 32'(rd_got), 32'h9D);
    check("R11 rx_pop", 32'(pop_got), 32'd1);
    bus_op(1'b1, 1'b0, 4'h3, 8'h00, 4'h0);
    check("R1 foreign data read", {23'd0, pop_got, rd_got}, 32'd0);

    // R2/R12: reset mid-sequence returns pointer to MR1
    bus_op(1'b0, 1'b1, 4'hA, 8'hB0, 4'h0);
    do_reset();
    check("R12 cfg after second reset", 32'(cfg_now()), 32'(c(0,0,0,1'b1,0,2'd0,0,0,0,3'd0,4'h0,4'h0)));
    bus_op(1'b0, 1'b1, 4'h8, 8'h02, 4'h0);
    check("R2 reset points at MR1", {29'd0, word_len, fifo_ext}, {29'd0, 2'd2, 1'b0});

    finish_run();
  end

endmodule